// File: doc/BRIEF.md
# Chip-Select Activity Watchdog

This block watches a chip-select line for signs of life from the host. Every edge on that line, rising or falling, restarts a tick counter. If the counter runs to its limit with no edge arriving, the block raises a one-clock expiry pulse. The neighbouring reset controller turns that pulse into a system reset on both its active-high and active-low outputs. The limit is the parameter `TIMEOUT_TICKS`. The default of 400,000,000 ticks gives the nominal 1.6 s timeout at a 250 MHz clock.

The counter is frozen at zero whenever any of three conditions holds: the supply is not good, the power-on stretch has not finished, or the external reset input is active. Counting therefore starts only at the later of two events: the end of the stretch, or the release of the external reset. The chip-select input is asynchronous. It passes through a synchroniser before edge detection.

The controller has four states:

- `WD_HOLD`: counter cleared, waiting for all hold conditions to clear.
- `WD_RUN`: counting.
- `WD_FIRE`: a single cycle carrying the expiry pulse.
- `WD_RECOVER`: counter parked at zero until the reset period caused by the expiry begins.

Its transitions are:

- HOLD→RUN when no hold condition is present.
- RUN→FIRE when the limit is reached without a kick.
- FIRE→RECOVER.
- Any state→HOLD whenever a hold condition appears.

Top module: `cs_watchdog`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `wd_expire` is 0 and `wd_count` is 0.
- R2: While `supply_ok` is 0, or `stretch_done` is 0, or `ext_rst_active` is 1, `wd_count` reads 0 one edge later and `wd_expire` stays 0.
- R3: Counting starts at the first clock edge at which all three hold conditions are clear, whichever of them clears last. With no chip-select edge, `wd_expire` is high after the (T+1)-th rising edge counted from that edge (that edge is 1), where T is `TIMEOUT_TICKS`.
- R4: While running, `wd_count` rises by one per clock. After the n-th edge from the release edge it reads n-1, and it never reaches T.
- R5: Any chip-select transition, rising or falling, restarts the count. With the new level first presented before edge g+1 after release, expiry follows edge g+T+3. This includes 2 synchroniser stages and 1 edge register. The last transition governs.
- R6: A kick that lands on the same edge as the limit is reached wins, and no pulse is issued.
- R7: `wd_expire` is exactly one clock wide, and `wd_count` reads 0 in the cycle after the pulse.
- R8: After an expiry, the counter stays at 0 and issues no further pulse until a hold condition is seen. Once that condition clears, it counts again as in R3.
- R9: A hold condition that appears mid-count clears `wd_count` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_in | input | 1 | Asynchronous chip-select line being watched |
| supply_ok | input | 1 | Supply above threshold |
| stretch_done | input | 1 | Power-on or reset stretch period has finished |
| ext_rst_active | input | 1 | External reset input currently asserted |
| wd_expire | output | 1 | One-clock timeout pulse toward the reset controller |
| wd_count | output | $clog2(TIMEOUT_TICKS) | Current tick count |

## Verification
The counting path is tried against several chip-select patterns:

- No edge at all, which yields the bare timeout length.
- A single edge at several offsets after release, which shows that restart timing includes the synchroniser latency.
- A pair of opposite edges, which shows that a falling edge restarts the count as well as a rising one and that the later edge governs.
- Edges placed just before, exactly at and just after the limit cycle, which separate a kick that rescues the count from one that arrives after the pulse.

The hold inputs are released in both orders to show that the later release starts the count. A hold is applied mid-count, and the expiry is left unanswered, to show the parked recovery state.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_HOLD    = 2'd0,
        WD_RUN     = 2'd1,
        WD_FIRE    = 2'd2,
        WD_RECOVER = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_cs_edge.sv
module wdog_cs_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_async,
    output logic cs_kick
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_lvl;

    genvar i;
    generate
        for (i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= cs_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= chain[LAST];
    end

    assign cs_kick = chain[LAST] ^ prev_lvl;

    // R5
    kick_is_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_kick |=> (prev_lvl == $past(chain[LAST])));
endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int LIMIT = 400_000_000,
    parameter int CW    = $clog2(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_limit
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == TOP);

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt == CW'($past(cnt) + 1'b1)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
endmodule

// File: rtl/wdog_ctrl_fsm.sv
module wdog_ctrl_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  logic      kick,
    input  logic      at_limit,
    output logic      cnt_clr,
    output logic      cnt_inc,
    output logic      expire,
    output wd_state_e state
);
    wd_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            WD_HOLD:    state_nx = hold ? WD_HOLD : WD_RUN;
            WD_RUN:     if (hold)                   state_nx = WD_HOLD;
                        else if (at_limit && !kick) state_nx = WD_FIRE;
                        else                        state_nx = WD_RUN;
            WD_FIRE:    state_nx = hold ? WD_HOLD : WD_RECOVER;
            WD_RECOVER: state_nx = hold ? WD_HOLD : WD_RECOVER;
            default:    state_nx = WD_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        cnt_clr = 1'b1;
        cnt_inc = 1'b0;
        expire  = 1'b0;
        unique case (state)
            WD_HOLD:    cnt_clr = 1'b1;
            WD_RUN: begin
                cnt_clr = hold || kick || at_limit;
                cnt_inc = 1'b1;
            end
            WD_FIRE:    expire  = 1'b1;
            WD_RECOVER: cnt_clr = 1'b1;
            default:    cnt_clr = 1'b1;
        endcase
    end

    // R7
    pulse_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R8
    park_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_FIRE) |=> (state != WD_RUN));

    // R8
    recover_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RECOVER && !hold) |=> (state == WD_RECOVER));
endmodule

// File: rtl/cs_watchdog.sv
module cs_watchdog
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 400_000_000,
    parameter int SYNC_STAGES   = 2,
    localparam int CW           = $clog2(TIMEOUT_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_in,
    input  logic          supply_ok,
    input  logic          stretch_done,
    input  logic          ext_rst_active,
    output logic          wd_expire,
    output logic [CW-1:0] wd_count
);
    logic      kick;
    logic      hold;
    logic      cnt_clr;
    logic      cnt_inc;
    logic      at_limit;
    wd_state_e state;

    assign hold = !supply_ok || !stretch_done || ext_rst_active;

    wdog_cs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_async (cs_in),
        .cs_kick  (kick)
    );

    wdog_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .kick     (kick),
        .at_limit (at_limit),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .expire   (wd_expire),
        .state    (state)
    );

    wdog_tick_counter #(.LIMIT(TIMEOUT_TICKS), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .cnt      (wd_count),
        .at_limit (at_limit)
    );

    // R2
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (wd_count == '0 && !wd_expire));

    // R5
    kick_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && state == WD_RUN) |=> (wd_count == '0 && !wd_expire));

    // R7
    zero_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> (wd_count == '0));
endmodule

// File: tb/sim_cs_watchdog.sv
module sim_cs_watchdog;
    localparam int T  = 40;
    localparam int CW = $clog2(T);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_in = 1'b0;
    logic          supply_ok = 1'b1;
    logic          stretch_done = 1'b0;
    logic          ext_rst_active = 1'b0;
    logic          wd_expire;
    logic [CW-1:0] wd_count;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // Each row: first toggle offset, second toggle offset (-1 = none), expected expiry edge.
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{-1,    -1, T + 1},
        '{ 0,    -1, T + 3},
        '{ 5,    -1, T + 8},
        '{ 5,     6, T + 9},
        '{10,    20, T + 23},
        '{T - 3, -1, 2 * T},
        '{T - 2, -1, 2 * T + 1},
        '{T - 1, -1, T + 1}
    };

    cs_watchdog #(.TIMEOUT_TICKS(T)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_in          (cs_in),
        .supply_ok      (supply_ok),
        .stretch_done   (stretch_done),
        .ext_rst_active (ext_rst_active),
        .wd_expire      (wd_expire),
        .wd_count       (wd_count)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Called at the negedge where the last hold condition was cleared.
    task automatic run_until_expire(input int g1, input int g2, output int n);
        n = 0;
        if (g1 == 0 || g2 == 0) cs_in = ~cs_in;
        for (int i = 1; i <= 2 * T + 10; i++) begin
            @(negedge clk);
            if (wd_expire) begin
                n = i;
                break;
            end
            if (i == g1 || i == g2) cs_in = ~cs_in;
        end
    endtask

    task automatic dip_release();
        @(negedge clk);
        stretch_done = 1'b0;
        repeat (3) @(negedge clk);
        stretch_done = 1'b1;
    endtask

    // Watch for quiet cycles: returns any expiry seen and the largest count.
    task automatic watch(input int cycles, output int seen, output int maxc);
        seen = 0;
        maxc = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (wd_expire) seen = 1;
            if (int'(wd_count) > maxc) maxc = int'(wd_count);
        end
    endtask

    initial begin
        int n;
        int seen;
        int maxc;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 expire in reset", int'(wd_expire), 0);
        chk("R1 count in reset", int'(wd_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 expire after reset", int'(wd_expire), 0);
        chk("R1 count after reset", int'(wd_count), 0);

        // R3 R5 R6: table of kick patterns
        for (int v = 0; v < NV; v++) begin
            dip_release();
            run_until_expire(VEC[v][0], VEC[v][1], n);
            chk($sformatf("R5 vector %0d expiry edge", v), n, VEC[v][2]);
            @(negedge clk);
            chk($sformatf("R7 vector %0d pulse width", v), int'(wd_expire), 0);
            chk($sformatf("R7 vector %0d count after", v), int'(wd_count), 0);
        end

        // R2: supply low holds everything
        @(negedge clk);
        supply_ok = 1'b0;
        watch(3 * T, seen, maxc);
        chk("R2 supply low no expiry", seen, 0);
        chk("R2 supply low count", maxc, 0);
        supply_ok = 1'b1;
        run_until_expire(-1, -1, n);
        chk("R3 supply release timeout", n, T + 1);

        // R3: external reset released first, stretch later
        @(negedge clk);
        ext_rst_active = 1'b1;
        stretch_done = 1'b0;
        @(negedge clk);
        ext_rst_active = 1'b0;
        watch(2 * T, seen, maxc);
        chk("R2 stretch pending no expiry", seen, 0);
        chk("R2 stretch pending count", maxc, 0);
        stretch_done = 1'b1;
        run_until_expire(-1, -1, n);
        chk("R3 stretch last timeout", n, T + 1);

        // R3: stretch ends first, external reset released later
        @(negedge clk);
        ext_rst_active = 1'b1;
        stretch_done = 1'b0;
        @(negedge clk);
        stretch_done = 1'b1;
        watch(2 * T, seen, maxc);
        chk("R2 ext reset no expiry", seen, 0);
        chk("R2 ext reset count", maxc, 0);
        ext_rst_active = 1'b0;
        run_until_expire(-1, -1, n);
        chk("R3 ext last timeout", n, T + 1);

        // R8: after expiry, parked until a hold is seen
        watch(3 * T, seen, maxc);
        chk("R8 no second pulse", seen, 0);
        chk("R8 parked count", maxc, 0);
        dip_release();
        run_until_expire(-1, -1, n);
        chk("R8 counts again after hold", n, T + 1);

        // R4 and R9: count progression and mid-count hold
        dip_release();
        repeat (5) @(negedge clk);
        chk("R4 count after 5 edges", int'(wd_count), 4);
        repeat (7) @(negedge clk);
        chk("R4 count after 12 edges", int'(wd_count), 11);
        ext_rst_active = 1'b1;
        @(negedge clk);
        chk("R9 hold clears count", int'(wd_count), 0);
        chk("R9 hold no expiry", int'(wd_expire), 0);
        ext_rst_active = 1'b0;
        run_until_expire(-1, -1, n);
        chk("R9 restart after hold", n, T + 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule